// File: doc/BRIEF.md
# GPIB Talker Source Handshake

This block is the sending half of the IEEE 488.1 three-wire byte handshake. A host loads one byte at a time, together with a flag that marks the last byte of a message. The block waits until the listeners are ready, puts the byte on the data lines, and waits a settling time. It then asserts DAV and holds it until every listener has accepted the byte. Finally it releases the bus and asks for the next byte.

The settling time is counted in ticks of 100 ns. Each tick lasts a programmed number of clock cycles, which tells the block the clock frequency. Three delay modes are available: standard, very short and user-set. Each mode has a longer value for the first byte of a transfer and a shorter value for the bytes that follow. EOI goes out with the last byte of a message. If end-string detection is enabled, EOI also goes out with any byte that equals the programmed end character, typically newline (0x0A).

All bus pins are active low. Controller functions, ATN command bytes, parallel poll and the transceivers are not part of this block.

Top module: `gpib_talk_hs`

## Requirements
- R1: After reset, byte_rdy is 1, dav_n and eoi_n are 1, dio_oe is 0 and dio_n is all ones.
- R2: A write (byte_valid while byte_rdy is 1) clears byte_rdy on the next cycle. A write made while byte_rdy is 0 is ignored and never reaches the bus.
- R3: The data lines are driven (dio_oe=1) only after the block has seen nrfd_n high and ndac_n low at the same time. Until then, DAV stays unasserted.
- R4: dav_n falls exactly ticks × div clock cycles after dio_oe rises. Here div is cfg_clk_div, and a div of 0 counts as 1.
- R5: Tick counts are selected by cfg_dly_mode. 2'b00 gives 20 ticks for the first byte and 5 for the following bytes. 2'b01 gives 11 and 4. For 2'b1x, the first byte takes u ticks and the following bytes take max(1, u>>1) ticks, where u is cfg_user_ticks and a value of 0 counts as 1.
- R6: The first-byte count applies after reset, after any byte sent with EOI, and after GAP_CYC (64) idle cycles with byte_rdy high and no write. In every other case the following-byte count applies.
- R7: DAV stays asserted until ndac_n is seen high. DAV, EOI and the data drive are then released together, and byte_rdy returns to 1.
- R8: EOI is asserted together with the data when byte_last is set. It is also asserted when cfg_eos_en is 1 and the byte equals cfg_eos_char. EOI is released together with DAV.
- R9: While the data lines are driven, dio_n carries the bitwise inverse of the written byte and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Write strobe for byte_data and byte_last |
| byte_data | input | 8 | Byte to send |
| byte_last | input | 1 | Byte ends the message; send it with EOI |
| byte_rdy | output | 1 | The block can accept a byte |
| cfg_clk_div | input | 4 | Clock cycles per 100 ns tick |
| cfg_dly_mode | input | 2 | Settling delay mode |
| cfg_user_ticks | input | 8 | Tick count for user-set mode |
| cfg_eos_en | input | 1 | Enable EOI on the end character |
| cfg_eos_char | input | 8 | End character |
| nrfd_n | input | 1 | NRFD bus line, active low |
| ndac_n | input | 1 | NDAC bus line, active low |
| dio_n | output | 8 | Data lines, active low |
| dio_oe | output | 1 | Drive enable for the data transceivers |
| dav_n | output | 1 | DAV bus line, active low |
| eoi_n | output | 1 | EOI bus line, active low |

## Verification
A wrong state register or wrong first-byte flag shows up at once as a DAV edge that is off by whole ticks on the next byte. A wrong tick count inside the timer gives an error of a single cycle, so the bench measures the interval from dio_oe to dav_n exactly rather than within a tolerance. A handshake state that skips its wait shows up within the two-cycle synchronizer latency, as data driven while the listener is holding NRFD low or as DAV released while NDAC is still low. An EOI decision taken at the wrong time shows up as a wrong eoi_n level while DAV is asserted.

// File: rtl/gpib_talk_pkg.sv
package gpib_talk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RFD    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DAC    = 2'd3
  } talk_st_t;

  localparam logic [1:0] DLY_STD    = 2'b00;
  localparam logic [1:0] DLY_VSHORT = 2'b01;
endpackage

// File: rtl/gpib_pin_sync.sv
module gpib_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpib_t1_select.sv
module gpib_t1_select
  import gpib_talk_pkg::*;
#(
  parameter int TICKW     = 8,
  parameter int STD_FIRST = 20,
  parameter int STD_NEXT  = 5,
  parameter int VS_FIRST  = 11,
  parameter int VS_NEXT   = 4
) (
  input  logic [1:0]       mode,
  input  logic             first,
  input  logic [TICKW-1:0] user_ticks,
  output logic [TICKW-1:0] ticks
);
  logic [TICKW-1:0] u_full;
  logic [TICKW-1:0] u_half;

  always_comb begin
    u_full = (user_ticks == '0) ? TICKW'(1) : user_ticks;
    u_half = (u_full >> 1) == '0 ? TICKW'(1) : (u_full >> 1);
    if (mode == DLY_STD)
      ticks = first ? TICKW'(STD_FIRST) : TICKW'(STD_NEXT);
    else if (mode == DLY_VSHORT)
      ticks = first ? TICKW'(VS_FIRST) : TICKW'(VS_NEXT);
    else
      ticks = first ? u_full : u_half;
  end
endmodule

// File: rtl/gpib_t1_timer.sv
module gpib_t1_timer #(
  parameter int DIVW  = 4,
  parameter int TICKW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIVW-1:0]  div,
  input  logic [TICKW-1:0] ticks,
  output logic             done
);
  logic [DIVW-1:0]  div_q;
  logic [DIVW-1:0]  pre;
  logic [TICKW-1:0] tk;
  logic             run;
  logic [DIVW-1:0]  div_eff;

  assign div_eff = (div == '0) ? DIVW'(1) : div;
  assign done    = run && (pre == '0) && (tk == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      pre   <= '0;
      tk    <= '0;
      div_q <= DIVW'(1);
    end else if (start) begin
      run   <= 1'b1;
      div_q <= div_eff;
      pre   <= div_eff - DIVW'(1);
      tk    <= ticks - TICKW'(1);
    end else if (run) begin
      if (pre == '0) begin
        if (tk == '0) begin
          run <= 1'b0;
        end else begin
          tk  <= tk - TICKW'(1);
          pre <= div_q - DIVW'(1);
        end
      end else begin
        pre <= pre - DIVW'(1);
      end
    end
  end

  AST_TMR_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done); // R4
endmodule

// File: rtl/gpib_talk_hs.sv
module gpib_talk_hs
  import gpib_talk_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DIVW      = 4,
  parameter int TICKW     = 8,
  parameter int GAP_CYC   = 64,
  parameter int SYNC_STG  = 2,
  parameter int STD_FIRST = 20,
  parameter int STD_NEXT  = 5,
  parameter int VS_FIRST  = 11,
  parameter int VS_NEXT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid,
  input  logic [DW-1:0]    byte_data,
  input  logic             byte_last,
  output logic             byte_rdy,
  input  logic [DIVW-1:0]  cfg_clk_div,
  input  logic [1:0]       cfg_dly_mode,
  input  logic [TICKW-1:0] cfg_user_ticks,
  input  logic             cfg_eos_en,
  input  logic [DW-1:0]    cfg_eos_char,
  input  logic             nrfd_n,
  input  logic             ndac_n,
  output logic [DW-1:0]    dio_n,
  output logic             dio_oe,
  output logic             dav_n,
  output logic             eoi_n
);
  localparam int GAPW = $clog2(GAP_CYC + 1);

  talk_st_t         st;
  logic [DW-1:0]    byte_q;
  logic             eoi_q;
  logic             data_oe;
  logic             dav;
  logic             eoi;
  logic             rdy;
  logic             first;
  logic [GAPW-1:0]  gap_cnt;
  logic [1:0]       pins_s;
  logic             rfd_s;
  logic             dac_s;
  logic             tmr_start;
  logic             tmr_done;
  logic [TICKW-1:0] ticks;
  logic             eos_hit;

  gpib_pin_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({nrfd_n, ndac_n}),
    .dout(pins_s)
  );
  assign rfd_s = pins_s[1];
  assign dac_s = pins_s[0];

  gpib_t1_select #(
    .TICKW(TICKW), .STD_FIRST(STD_FIRST), .STD_NEXT(STD_NEXT),
    .VS_FIRST(VS_FIRST), .VS_NEXT(VS_NEXT)
  ) u_sel (
    .mode      (cfg_dly_mode),
    .first     (first),
    .user_ticks(cfg_user_ticks),
    .ticks     (ticks)
  );

  gpib_t1_timer #(.DIVW(DIVW), .TICKW(TICKW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(tmr_start),
    .div  (cfg_clk_div),
    .ticks(ticks),
    .done (tmr_done)
  );

  assign eos_hit   = cfg_eos_en && (byte_data == cfg_eos_char);
  assign tmr_start = (st == ST_RFD) && rfd_s && !dac_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      byte_q  <= '0;
      eoi_q   <= 1'b0;
      data_oe <= 1'b0;
      dav     <= 1'b0;
      eoi     <= 1'b0;
      rdy     <= 1'b1;
      first   <= 1'b1;
      gap_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (byte_valid) begin
            byte_q  <= byte_data;
            eoi_q   <= byte_last || eos_hit;
            rdy     <= 1'b0;
            gap_cnt <= '0;
            st      <= ST_RFD;
          end else if (gap_cnt == GAPW'(GAP_CYC - 1)) begin
            first <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt + GAPW'(1);
          end
        end
        ST_RFD: begin
          if (tmr_start) begin
            data_oe <= 1'b1;
            eoi     <= eoi_q;
            st      <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_done) begin
            dav <= 1'b1;
            st  <= ST_DAC;
          end
        end
        default: begin
          if (dac_s) begin
            dav     <= 1'b0;
            eoi     <= 1'b0;
            data_oe <= 1'b0;
            rdy     <= 1'b1;
            first   <= eoi;
            st      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign byte_rdy = rdy;
  assign dio_oe   = data_oe;
  assign dio_n    = data_oe ? ~byte_q : '1;
  assign dav_n    = ~dav;
  assign eoi_n    = ~eoi;

  AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
    byte_valid && byte_rdy |=> !byte_rdy); // R2
  AST_DAV_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    !dav_n |-> dio_oe); // R3
  AST_DAV_HOLDS: assert property (@(posedge clk) disable iff (rst)
    dav && !dac_s |=> dav); // R7
  AST_EOI_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    !eoi_n |-> dio_oe); // R8
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    dio_oe |=> (!dio_oe || $stable(dio_n))); // R9
  AST_T1_NONZERO: assert property (@(posedge clk) disable iff (rst)
    tmr_start |-> ticks != '0); // R5
endmodule

// File: tb/tb_gpib_talk_hs.sv
module tb_gpib_talk_hs;
  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] div;
    logic [7:0] usr;
    logic [7:0] dat;
    logic       last;
    logic       eos_en;
    logic [7:0] eos;
    logic [9:0] dly;
    logic       eoi;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd2, 8'd0, 8'h41, 1'b0, 1'b0, 8'h0A, 10'd40, 1'b0},
    '{2'd0, 4'd2, 8'd0, 8'h42, 1'b0, 1'b0, 8'h0A, 10'd10, 1'b0},
    '{2'd0, 4'd2, 8'd0, 8'h0A, 1'b0, 1'b1, 8'h0A, 10'd10, 1'b1},
    '{2'd1, 4'd3, 8'd0, 8'h0A, 1'b0, 1'b0, 8'h0A, 10'd33, 1'b0},
    '{2'd1, 4'd3, 8'd0, 8'h55, 1'b1, 1'b0, 8'h0A, 10'd12, 1'b1},
    '{2'd2, 4'd1, 8'd7, 8'h00, 1'b0, 1'b0, 8'h0A, 10'd7,  1'b0},
    '{2'd2, 4'd1, 8'd7, 8'hFF, 1'b0, 1'b0, 8'h0A, 10'd3,  1'b0},
    '{2'd3, 4'd0, 8'd1, 8'h3C, 1'b1, 1'b0, 8'h0A, 10'd1,  1'b1},
    '{2'd0, 4'd1, 8'd0, 8'h80, 1'b0, 1'b0, 8'h0A, 10'd20, 1'b0},
    '{2'd0, 4'd1, 8'd0, 8'h0A, 1'b0, 1'b1, 8'h0B, 10'd5,  1'b0},
    '{2'd1, 4'd4, 8'd0, 8'hC3, 1'b1, 1'b0, 8'h0A, 10'd16, 1'b1},
    '{2'd2, 4'd2, 8'd0, 8'h5A, 1'b1, 1'b0, 8'h0A, 10'd2,  1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       byte_last = 1'b0;
  logic       byte_rdy;
  logic [3:0] cfg_clk_div = 4'd1;
  logic [1:0] cfg_dly_mode = 2'd0;
  logic [7:0] cfg_user_ticks = '0;
  logic       cfg_eos_en = 1'b0;
  logic [7:0] cfg_eos_char = 8'h0A;
  logic       nrfd_n = 1'b1;
  logic       ndac_n = 1'b0;
  logic [7:0] dio_n;
  logic       dio_oe;
  logic       dav_n;
  logic       eoi_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpib_talk_hs dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_last(byte_last), .byte_rdy(byte_rdy), .cfg_clk_div(cfg_clk_div),
    .cfg_dly_mode(cfg_dly_mode), .cfg_user_ticks(cfg_user_ticks),
    .cfg_eos_en(cfg_eos_en), .cfg_eos_char(cfg_eos_char), .nrfd_n(nrfd_n),
    .ndac_n(ndac_n), .dio_n(dio_n), .dio_oe(dio_oe), .dav_n(dav_n), .eoi_n(eoi_n)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    byte_data  = d;
    byte_last  = l;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // Waits for data drive, measures cycles to DAV, then accepts the byte.
  task automatic run_byte(output int dly, output logic eoi_seen, output logic [7:0] dio_seen,
                          output logic rel_ok);
    int guard;
    guard = 0;
    while (!dio_oe && guard < 5000) begin @(negedge clk); guard++; end
    dly = 0;
    while (dav_n && dly < 5000) begin @(negedge clk); dly++; end
    eoi_seen = !eoi_n;
    dio_seen = dio_n;
    ndac_n = 1'b1;
    guard = 0;
    while (!dav_n && guard < 20) begin @(negedge clk); guard++; end
    rel_ok = dav_n && eoi_n && !dio_oe && byte_rdy;
    ndac_n = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int         dly;
    logic       e;
    logic [7:0] dv;
    logic       rok;
    logic       ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(byte_rdy == 1'b1, "R1 byte_rdy", byte_rdy, 1);
    chk(dav_n == 1'b1, "R1 dav_n", dav_n, 1);
    chk(eoi_n == 1'b1, "R1 eoi_n", eoi_n, 1);
    chk(dio_oe == 1'b0, "R1 dio_oe", dio_oe, 0);
    chk(dio_n == 8'hFF, "R1 dio_n", dio_n, 255);

    // Vector table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_dly_mode   = VEC[i].mode;
      cfg_clk_div    = VEC[i].div;
      cfg_user_ticks = VEC[i].usr;
      cfg_eos_en     = VEC[i].eos_en;
      cfg_eos_char   = VEC[i].eos;
      write_byte(VEC[i].dat, VEC[i].last);
      run_byte(dly, e, dv, rok);
      chk(dly == int'(VEC[i].dly), "R4/R5/R6 delay", dly, int'(VEC[i].dly));
      chk(e == VEC[i].eoi, "R8 eoi", e, VEC[i].eoi);
      chk(dv == ~VEC[i].dat, "R9 dio_n", dv, int'(~VEC[i].dat));
      chk(rok, "R7 release", rok, 1);
    end

    // R2 / R3 / R7: listener holds NRFD low, then NDAC low after DAV
    cfg_dly_mode = 2'd0; cfg_clk_div = 4'd1; cfg_eos_en = 1'b0;
    @(negedge clk);
    nrfd_n = 1'b0;
    write_byte(8'h6E, 1'b0);
    chk(byte_rdy == 1'b0, "R2 rdy cleared", byte_rdy, 0);
    repeat (30) @(negedge clk);
    chk(dio_oe == 1'b0 && dav_n == 1'b1, "R3 wait NRFD", dio_oe, 0);
    byte_data = 8'h99; byte_valid = 1'b1;        // R2 write while busy
    @(negedge clk);
    byte_valid = 1'b0;
    nrfd_n = 1'b1;
    dly = 0;
    while (!dio_oe && dly < 100) begin @(negedge clk); dly++; end
    dly = 0;
    while (dav_n && dly < 200) begin @(negedge clk); dly++; end
    chk(dly == 20, "R6 first after EOI", dly, 20);
    repeat (40) @(negedge clk);
    chk(dav_n == 1'b0, "R7 DAV held", dav_n, 0);
    chk(dio_n == 8'h91, "R2 busy write ignored", dio_n, 8'h91);
    ndac_n = 1'b1;
    repeat (5) @(negedge clk);
    ndac_n = 1'b0;
    chk(dav_n && !dio_oe && byte_rdy, "R7 release", dav_n, 1);
    ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dio_oe) ok = 1'b0;
    end
    chk(ok, "R2 no second byte", ok, 1);

    // R3: NDAC still high blocks the data drive
    ndac_n = 1'b1;
    write_byte(8'h12, 1'b0);
    repeat (10) @(negedge clk);
    chk(dio_oe == 1'b0, "R3 wait NDAC low", dio_oe, 0);
    ndac_n = 1'b0;
    run_byte(dly, e, dv, rok);
    chk(dly == 5, "R6 next byte", dly, 5);

    // R6: idle gap and reset restore the first-byte delay
    repeat (72) @(negedge clk);
    write_byte(8'h33, 1'b0);
    run_byte(dly, e, dv, rok);
    chk(dly == 20, "R6 after idle gap", dly, 20);
    write_byte(8'h44, 1'b0);
    run_byte(dly, e, dv, rok);
    chk(dly == 5, "R6 continuing", dly, 5);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    write_byte(8'h55, 1'b0);
    run_byte(dly, e, dv, rok);
    chk(dly == 20, "R6 after reset", dly, 20);
    chk(e == 1'b0, "R8 no eoi", e, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule